// File: doc/BRIEF.md
# Raster Beam Timer Interrupt Controller

This block watches the horizontal and vertical beam counters of a raster display. It raises a level interrupt request when the counters reach compare positions that software has programmed. Software writes a control byte and two 9-bit compare positions through an 8-bit register port. The control byte selects one of three match modes: horizontal only, vertical only, or both. The request stays high until an acknowledge pulse clears it. A control write that turns off both timers drops it at once. A control write that selects vertical-only mode while the request is high produces a fresh rising edge.

The same control byte enables a non-maskable interrupt at the start of vertical blank. The NMI output is a one-cycle pulse. If software sets the NMI enable while the beam is already inside vertical blank and the external NMI-pending flag is still set, the pulse is issued at once. It does not wait for the next blanking period. The counters advance on a `beam_tick` strobe, and compares are evaluated only on cycles where that strobe is high.

Top module: `beam_irq_ctrl`

## Requirements
- R1: After reset, `irq` and `nmi` are 0, all three enables are off and both compare positions are 0.
- R2: A write to register 0 sets the control byte. Bit 7 enables the vblank NMI, bit 5 enables the vertical timer and bit 4 enables the horizontal timer. All other bits are ignored.
- R3: The horizontal compare low byte is at register 1 and its high byte at register 3. The vertical compare low byte is at register 2 and its high byte at register 4. The low register sets bits [7:0]. Only bit 0 of the high register is kept, as bit 8, and its bits [7:1] are ignored.
- R4: In horizontal-only mode, a `beam_tick` cycle with `h_count` equal to the horizontal compare makes `irq` 1 on the following cycle, on any line.
- R5: In vertical-only mode, a `beam_tick` cycle with `v_count` equal to the vertical compare and `h_count` equal to 0 sets `irq` on the following cycle. The same `v_count` with a nonzero `h_count` does not set it.
- R6: With both timers enabled, `irq` is set only when both counters equal their compares on a `beam_tick` cycle.
- R7: `irq` holds until an `irq_ack` cycle, and it reads 0 on the cycle after that ack. If an ack and a new match arrive in the same cycle, `irq` stays 1.
- R8: A control write that leaves both timers disabled makes `irq` 0 on the next cycle. This takes priority over an ack, over a retrigger and over a match in the same cycle.
- R9: A control write selecting vertical-only mode while `irq` is 1 forces `irq` to 0 for exactly one cycle and then back to 1.
- R10: A compare-register write takes effect for ticks after the write cycle. A tick in the write cycle itself is compared against the old value.
- R11: With NMI enabled, a rise of `in_vblank` makes `nmi` 1 for exactly one cycle, on the cycle after the rise is seen.
- R12: A control write that changes the NMI enable from 0 to 1, made while `in_vblank` and `nmi_flag` are both 1, makes `nmi` 1 for one cycle on the next cycle. The same write with `nmi_flag` at 0 produces no pulse, and so does a rewrite while the enable is already 1.
- R13: Counters that equal the compares produce no `irq` unless `beam_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0 control, 1 H low, 2 V low, 3 H high, 4 V high) |
| wr_data | input | 8 | Write data |
| beam_tick | input | 1 | Counter advance strobe; compares are evaluated only on these cycles |
| h_count | input | 9 | Horizontal beam counter |
| v_count | input | 9 | Vertical beam counter |
| in_vblank | input | 1 | High while the beam is in vertical blank |
| nmi_flag | input | 1 | NMI-pending status, not yet read back by software |
| irq_ack | input | 1 | Clears the pending interrupt request |
| irq | output | 1 | Level interrupt request |
| nmi | output | 1 | One-cycle NMI pulse |

## Verification
Several paths drive the request flop and can collide in one cycle: a counter match, an acknowledge, a timer-off control write, and a vertical-only retrigger. The bench makes them collide on purpose. It pairs an ack with a matching tick, and it pairs a timer-off write with both a matching tick and an ack. For each collision it checks the request on the following cycle against the priority the requirements give: clear beats everything, and a match beats an ack. A compare rewrite in the same cycle as a tick is also provoked, and the tick must be judged against the old position. Randomly chosen modes and counters, half of them steered onto the compares, are checked against a bench function that decides from the requirements whether each tick should hit.

// File: rtl/beam_irq_pkg.sv
package beam_irq_pkg;

   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_H_LO  = 3'd1,
      SEL_V_LO  = 3'd2,
      SEL_H_HI  = 3'd3,
      SEL_V_HI  = 3'd4
   } reg_sel_e;

   localparam int CTL_NMI_BIT = 7;
   localparam int CTL_VEN_BIT = 5;
   localparam int CTL_HEN_BIT = 4;

   typedef struct packed {
      logic nmi_en;
      logic v_en;
      logic h_en;
   } ctl_t;

endpackage

// File: rtl/beam_irq_regs.sv
module beam_irq_regs
   import beam_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int POS_W  = 9,
   parameter int ADDR_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output ctl_t                  ctl,
   output logic [POS_W-1:0]      h_cmp,
   output logic [POS_W-1:0]      v_cmp,
   output logic                  ev_timers_off,
   output logic                  ev_vonly,
   output logic                  ev_nmi_arm
);

   localparam int HI_W   = POS_W - DATA_W;
   localparam int N_AXIS = 2;

   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
      $error("beam_irq_regs: POS_W must lie in DATA_W+1 .. 2*DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("beam_irq_regs: ADDR_W must be at least 3");
   end

   logic ctl_wr;
   assign ctl_wr = wr_en && (wr_addr == ADDR_W'(SEL_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (ctl_wr) begin
         ctl.nmi_en <= wr_data[CTL_NMI_BIT];
         ctl.v_en   <= wr_data[CTL_VEN_BIT];
         ctl.h_en   <= wr_data[CTL_HEN_BIT];
      end
   end

   logic [N_AXIS-1:0][POS_W-1:0] pos_w;

   // axis 0 = horizontal, axis 1 = vertical; low bytes at 1/2, high at 3/4
   for (genvar ax = 0; ax < N_AXIS; ax++) begin : g_axis
      localparam logic [ADDR_W-1:0] LO_SEL = ADDR_W'(1 + ax);
      localparam logic [ADDR_W-1:0] HI_SEL = ADDR_W'(3 + ax);
      logic [POS_W-1:0] pos_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_r <= '0;
         end else if (wr_en) begin
            if (wr_addr == LO_SEL) pos_r[DATA_W-1:0]     <= wr_data;
            if (wr_addr == HI_SEL) pos_r[POS_W-1:DATA_W] <= wr_data[HI_W-1:0];
         end
      end
      assign pos_w[ax] = pos_r;
   end

   assign h_cmp = pos_w[0];
   assign v_cmp = pos_w[1];

   assign ev_timers_off = ctl_wr && !wr_data[CTL_VEN_BIT] && !wr_data[CTL_HEN_BIT];
   assign ev_vonly      = ctl_wr &&  wr_data[CTL_VEN_BIT] && !wr_data[CTL_HEN_BIT];
   assign ev_nmi_arm    = ctl_wr &&  wr_data[CTL_NMI_BIT] && !ctl.nmi_en;

   assert_ctl_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (ctl.h_en == $past(wr_data[CTL_HEN_BIT])) &&
                 (ctl.v_en == $past(wr_data[CTL_VEN_BIT])) &&
                 (ctl.nmi_en == $past(wr_data[CTL_NMI_BIT])));

   assert_hi_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(SEL_H_HI)) |=>
         (h_cmp[POS_W-1:DATA_W] == $past(wr_data[HI_W-1:0])) && $stable(h_cmp[DATA_W-1:0]));

endmodule

// File: rtl/beam_irq_match.sv
module beam_irq_match #(
   parameter int POS_W    = 9,
   parameter int H_ORIGIN = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [POS_W-1:0] h_count,
   input  logic [POS_W-1:0] v_count,
   input  logic [POS_W-1:0] h_cmp,
   input  logic [POS_W-1:0] v_cmp,
   input  logic             h_en,
   input  logic             v_en,
   input  logic             ack,
   input  logic             clr,
   input  logic             retrig_req,
   output logic             irq
);

   localparam logic [POS_W-1:0] H_ZERO = POS_W'(H_ORIGIN);

   if (H_ORIGIN < 0 || H_ORIGIN >= (1 << POS_W)) begin : g_bad_origin
      $error("beam_irq_match: H_ORIGIN out of counter range");
   end

   logic h_eq, v_eq, h_at_origin, hit;
   logic irq_q, retrig_q;

   assign h_eq        = (h_count == h_cmp);
   assign v_eq        = (v_count == v_cmp);
   assign h_at_origin = (h_count == H_ZERO);

   always_comb begin
      unique case ({h_en, v_en})
         2'b10:   hit = h_eq;
         2'b01:   hit = v_eq && h_at_origin;
         2'b11:   hit = h_eq && v_eq;
         default: hit = 1'b0;
      endcase
      hit = hit && tick;
   end

   // priority: clear > retrigger drop > retrigger rise > match > ack
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q    <= 1'b0;
         retrig_q <= 1'b0;
      end else if (clr) begin
         irq_q    <= 1'b0;
         retrig_q <= 1'b0;
      end else if (retrig_req && irq_q) begin
         irq_q    <= 1'b0;
         retrig_q <= 1'b1;
      end else if (retrig_q) begin
         irq_q    <= 1'b1;
         retrig_q <= 1'b0;
      end else if (hit) begin
         irq_q    <= 1'b1;
      end else if (ack) begin
         irq_q    <= 1'b0;
      end
   end

   assign irq = irq_q;

   assert_hmatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && h_en && !v_en && h_count == h_cmp && !clr && !retrig_req) |=> irq);

   assert_vmatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && v_en && !h_en && v_count == v_cmp && h_count == H_ZERO && !clr && !retrig_req)
         |=> irq);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack && !clr && !retrig_req) |=> irq);

   assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !irq);

   assert_retrig_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retrig_req && irq && !clr) |=> (!irq && retrig_q));

   assert_retrig_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retrig_q && !clr) |=> irq);

   assert_no_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !tick && !retrig_q) |=> !irq);

endmodule

// File: rtl/beam_irq_nmi.sv
module beam_irq_nmi (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vblank,
   input  logic nmi_flag,
   input  logic nmi_en,
   input  logic arm_req,
   output logic nmi
);

   logic vb_q, nmi_q;
   logic vbl_start, late_arm;

   assign vbl_start = in_vblank && !vb_q && nmi_en;
   assign late_arm  = arm_req && in_vblank && nmi_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vb_q  <= 1'b0;
         nmi_q <= 1'b0;
      end else begin
         vb_q  <= in_vblank;
         nmi_q <= vbl_start || late_arm;
      end
   end

   assign nmi = nmi_q;

   assert_vbl_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(in_vblank) && nmi_en) |=> nmi);

   assert_late_arm_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_req && in_vblank && nmi_flag) |=> nmi);

   assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_vblank) |=> !nmi);

endmodule

// File: rtl/beam_irq_ctrl.sv
module beam_irq_ctrl
   import beam_irq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int POS_W    = 9,
   parameter int ADDR_W   = 3,
   parameter int H_ORIGIN = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              beam_tick,
   input  logic [POS_W-1:0]  h_count,
   input  logic [POS_W-1:0]  v_count,
   input  logic              in_vblank,
   input  logic              nmi_flag,
   input  logic              irq_ack,
   output logic              irq,
   output logic              nmi
);

   if (DATA_W <= CTL_NMI_BIT) begin : g_bad_data
      $error("beam_irq_ctrl: DATA_W too narrow for the control bits");
   end

   ctl_t             ctl;
   logic [POS_W-1:0] h_cmp, v_cmp;
   logic             ev_timers_off, ev_vonly, ev_nmi_arm;

   beam_irq_regs #(
      .DATA_W (DATA_W),
      .POS_W  (POS_W),
      .ADDR_W (ADDR_W)
   ) regs_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .ctl           (ctl),
      .h_cmp         (h_cmp),
      .v_cmp         (v_cmp),
      .ev_timers_off (ev_timers_off),
      .ev_vonly      (ev_vonly),
      .ev_nmi_arm    (ev_nmi_arm)
   );

   beam_irq_match #(
      .POS_W    (POS_W),
      .H_ORIGIN (H_ORIGIN)
   ) match_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (beam_tick),
      .h_count    (h_count),
      .v_count    (v_count),
      .h_cmp      (h_cmp),
      .v_cmp      (v_cmp),
      .h_en       (ctl.h_en),
      .v_en       (ctl.v_en),
      .ack        (irq_ack),
      .clr        (ev_timers_off),
      .retrig_req (ev_vonly),
      .irq        (irq)
   );

   beam_irq_nmi nmi_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vblank (in_vblank),
      .nmi_flag  (nmi_flag),
      .nmi_en    (ctl.nmi_en),
      .arm_req   (ev_nmi_arm),
      .nmi       (nmi)
   );

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!irq && !nmi));

endmodule

// File: tb/beam_irq_ctrl_tb.sv
`timescale 1ns/1ps
module beam_irq_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       beam_tick = 1'b0;
   logic [8:0] h_count = '0;
   logic [8:0] v_count = '0;
   logic       in_vblank = 1'b0;
   logic       nmi_flag = 1'b0;
   logic       irq_ack = 1'b0;
   logic       irq, nmi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   beam_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .beam_tick(beam_tick), .h_count(h_count), .v_count(v_count),
      .in_vblank(in_vblank), .nmi_flag(nmi_flag), .irq_ack(irq_ack),
      .irq(irq), .nmi(nmi)
   );

   function automatic bit exp_hit(bit he, bit ve, logic [8:0] h, logic [8:0] v,
                                  logic [8:0] hc, logic [8:0] vc);
      if (he && !ve) return h == hc;
      if (ve && !he) return (v == vc) && (h == 9'd0);
      if (he && ve)  return (h == hc) && (v == vc);
      return 1'b0;
   endfunction

   task automatic chk(string tag, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic tick_at(logic [8:0] h, logic [8:0] v);
      h_count = h; v_count = v; beam_tick = 1'b1;
      step();
      beam_tick = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      step();
      irq_ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [8:0] hc, vc, h, v;
      int mode;
      bit he, ve;
      repeat (3) step();
      chk("R1 irq after reset", irq, 1'b0);
      chk("R1 nmi after reset", nmi, 1'b0);
      rst_n = 1'b1;
      step();
      // R1: compares reset to 0 -> H-only tick at h=0 hits
      wr(3'd0, 8'h10);
      tick_at(9'd0, 9'd7);
      chk("R1 H compare resets to 0", irq, 1'b1);
      ack();
      chk("R7 ack clears", irq, 1'b0);

      // R3: H compare = 0x134, high byte bits 7:1 ignored
      wr(3'd1, 8'h34);
      wr(3'd3, 8'hFF);
      tick_at(9'h034, 9'd0);
      chk("R3 bit8 from high register", irq, 1'b0);
      tick_at(9'h134, 9'd0);
      chk("R4 H-only hit", irq, 1'b1);
      ack();
      tick_at(9'h134, 9'd200);
      chk("R4 H-only any line", irq, 1'b1);
      ack();

      // R5: V-only, V compare = 5
      wr(3'd2, 8'h05);
      wr(3'd4, 8'hFE);
      wr(3'd0, 8'h20);
      tick_at(9'd3, 9'd5);
      chk("R5 V-only needs h=0", irq, 1'b0);
      tick_at(9'd0, 9'd5);
      chk("R5 V-only hit", irq, 1'b1);
      ack();
      tick_at(9'd0, 9'h105);
      chk("R3 V high bit0 ignored bits", irq, 1'b0);

      // R6: both
      wr(3'd0, 8'h30);
      tick_at(9'h134, 9'd4);
      chk("R6 only H matches", irq, 1'b0);
      tick_at(9'h000, 9'd5);
      chk("R6 only V matches", irq, 1'b0);
      tick_at(9'h134, 9'd5);
      chk("R6 both match", irq, 1'b1);

      // R7: sticky, ack+match collision
      repeat (3) step();
      chk("R7 held without ack", irq, 1'b1);
      irq_ack = 1'b1;
      tick_at(9'h134, 9'd5);
      irq_ack = 1'b0;
      chk("R7 match beats ack", irq, 1'b1);
      ack();
      chk("R7 ack clears after collision", irq, 1'b0);

      // R13: no tick, no irq
      h_count = 9'h134; v_count = 9'd5;
      repeat (2) step();
      chk("R13 no tick no irq", irq, 1'b0);

      // R8: timer-off write beats match and ack
      tick_at(9'h134, 9'd5);
      chk("R6 re-hit", irq, 1'b1);
      h_count = 9'h134; v_count = 9'd5; beam_tick = 1'b1; irq_ack = 1'b1;
      wr(3'd0, 8'h00);
      beam_tick = 1'b0; irq_ack = 1'b0;
      chk("R8 off write clears", irq, 1'b0);
      step();
      chk("R8 stays clear", irq, 1'b0);

      // R9: V-only retrigger
      wr(3'd0, 8'h10);
      tick_at(9'h134, 9'd0);
      chk("R9 setup irq", irq, 1'b1);
      wr(3'd0, 8'h20);
      chk("R9 drop cycle", irq, 1'b0);
      step();
      chk("R9 rise again", irq, 1'b1);
      step();
      chk("R9 held after retrigger", irq, 1'b1);
      wr(3'd0, 8'h10);
      chk("R9 H-only write no drop", irq, 1'b1);
      ack();

      // R10: compare write in same cycle as tick uses old value
      h_count = 9'h134; v_count = 9'd0; beam_tick = 1'b1;
      wr(3'd1, 8'h40);
      beam_tick = 1'b0;
      chk("R10 tick uses old compare", irq, 1'b1);
      ack();
      tick_at(9'h134, 9'd0);
      chk("R10 old compare gone", irq, 1'b0);
      tick_at(9'h140, 9'd0);
      chk("R10 new compare hits", irq, 1'b1);
      ack();

      // R11: vblank start NMI
      wr(3'd0, 8'h80);
      chk("R11 no nmi outside vblank", nmi, 1'b0);
      in_vblank = 1'b1;
      step();
      chk("R11 pulse at vblank start", nmi, 1'b1);
      step();
      chk("R11 pulse one cycle", nmi, 1'b0);

      // R12: late enable
      wr(3'd0, 8'h00);
      nmi_flag = 1'b1;
      wr(3'd0, 8'h80);
      chk("R12 late enable fires", nmi, 1'b1);
      step();
      chk("R12 late pulse one cycle", nmi, 1'b0);
      wr(3'd0, 8'h80);
      chk("R12 rewrite no pulse", nmi, 1'b0);
      wr(3'd0, 8'h00);
      nmi_flag = 1'b0;
      wr(3'd0, 8'h80);
      chk("R12 flag clear no pulse", nmi, 1'b0);
      in_vblank = 1'b0;
      wr(3'd0, 8'h00);
      step();

      // random phase
      void'($urandom(32'd7));
      for (int i = 0; i < 300; i++) begin
         hc = 9'($urandom); vc = 9'($urandom);
         wr(3'd1, hc[7:0]); wr(3'd3, {7'($urandom), hc[8]});
         wr(3'd2, vc[7:0]); wr(3'd4, {7'($urandom), vc[8]});
         mode = 1 + int'($urandom % 3);
         he = mode[0]; ve = mode[1];
         wr(3'd0, {2'b00, ve, he, 4'($urandom)});
         h = ($urandom % 2) ? hc : 9'($urandom);
         v = ($urandom % 2) ? vc : 9'($urandom);
         if (ve && !he && ($urandom % 2)) h = 9'd0;
         tick_at(h, v);
         chk(he && ve ? "R6 random" : (he ? "R4 random" : "R5 random"),
             irq, exp_hit(he, ve, h, v, hc, vc));
         ack();
         chk("R7 random ack", irq, 1'b0);
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule